// File: doc/BRIEF.md
# Table-Access Bridge for a 24-bit Program Memory

This block connects a 16-bit data path to a program memory whose words are 24 bits wide. A request carries an 8-bit page value and a 16-bit effective address. The bridge joins them into a program word index and serves six operations: a read of the low 16 bits, a read of the upper 8 bits, a write of either part into a row staging latch, a single-word program, a full-row program and a page erase. Both the low and the high operations can work on a whole half or on one byte. In byte mode, bit 0 of the effective address picks the byte.

Table writes never touch the array directly. They fill a 64-entry staging latch of 24-bit words. A later program command merges the latch into the array, either one word or one row at a time. Programming can only clear bits: each array word becomes its old value ANDed with the latch entry. An erase sets a page-aligned group of 512 words back to all ones. While a multi-cycle operation runs, the bridge reports busy. A request that arrives during that time is dropped and raises a one-cycle error flag. The array itself is outside the block, behind a simple port with a one-cycle read latency.

Top module: `tbl_bridge`

## Requirements
- R1: The word index on `mem_addr` is {page_sel[7:0], eff_addr[15:1]}. Bit 0 of the effective address plays no part in it. `mem_cfg` equals page_sel[7], which selects configuration space rather than user space.
- R2: Operation codes are 0 read-low, 1 read-high, 2 write-low, 3 write-high, 4 program-word, 5 program-row, 6 erase-page and 7 no-operation. The bridge presents a read on the memory port in the cycle after it accepts the read. `rd_valid` pulses for one cycle two clock edges after acceptance, and `busy` stays high in between.
- R3: A read-low in word mode returns bits 15:0 of the word. In byte mode it returns bits 15:8 when eff_addr[0]=1 and bits 7:0 when eff_addr[0]=0, in both cases zero-extended.
- R4: A read-high returns bits 23:16 in rd_data[7:0] with rd_data[15:8]=0, in word mode and in byte mode with eff_addr[0]=0. A byte-mode read-high with eff_addr[0]=1 returns 0.
- R5: Write-low and write-high update staging entry eff_addr[6:1] only. Word-mode write-low sets bits 15:0. Byte-mode write-low sets bits 15:8 (eff_addr[0]=1) or bits 7:0 (eff_addr[0]=0) from wr_data[7:0]. Write-high, in word mode or in byte mode with eff_addr[0]=0, sets bits 23:16 from wr_data[7:0]. A byte-mode write-high with eff_addr[0]=1 has no effect. Writes never change the array and never raise busy.
- R6: Program-row works on the 64-word row that contains the word index. Each word becomes old AND staging[k], where k is the word's position in the row. Busy lasts exactly 128 cycles.
- R7: Program-word changes only the addressed word, to old AND staging[word index mod 64]. Busy lasts exactly 2 cycles.
- R8: Erase-page sets the 512 words of the page-aligned region that contains the word index to 24'hFFFFFF and leaves words outside it unchanged. Busy lasts exactly 512 cycles.
- R9: A request presented while busy is high is ignored and has no effect on the latch, the array or rd_valid. `err` is high for exactly the following cycle.
- R10: After reset, busy, rd_valid and err are low and every staging entry is all ones. Any staging entry consumed by a program command is restored to all ones.
- R11: Operation code 7 accepted while idle does nothing: no busy, no error, no read result, no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| page_sel | input | 8 | Page value, upper bits of the word index |
| eff_addr | input | 16 | Effective address |
| wr_data | input | 16 | Table write data |
| rd_data | output | 16 | Table read result |
| rd_valid | output | 1 | One-cycle read result strobe |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Request rejected while busy |
| mem_rd_en | output | 1 | Array read enable |
| mem_we | output | 1 | Array write enable |
| mem_cfg | output | 1 | Configuration space select |
| mem_addr | output | 23 | Array word index |
| mem_wdata | output | 24 | Array write data |
| mem_rdata | input | 24 | Array read data, one cycle after the read enable |

## Verification
The block keeps state in two places: the staging latch, which software cannot read back directly, and the sequencer counter. A latch entry that was corrupted, placed at the wrong index or never cleared shows up only when a program command runs. The result appears as wrong array contents at the next read, and tests read the array a few cycles after each program step. A sequencer counter that stops early or runs past its end shows at once in the busy length, which is counted exactly, and in words at or just outside the region edges, which are read back. A mistake in the address path shows in the same cycle on `mem_addr` and `mem_cfg` during a read, and in data taken from the wrong half of the model.

// File: rtl/tbl_pkg.sv
package tbl_pkg;

  typedef enum logic [2:0] {
    OP_RD_LO      = 3'd0,
    OP_RD_HI      = 3'd1,
    OP_WR_LO      = 3'd2,
    OP_WR_HI      = 3'd3,
    OP_PROG_WORD  = 3'd4,
    OP_PROG_ROW   = 3'd5,
    OP_ERASE_PAGE = 3'd6,
    OP_NOP        = 3'd7
  } tbl_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ISSUE,
    S_RD_CAP,
    S_PG_RD,
    S_PG_WR,
    S_ERASE
  } seq_state_e;

endpackage

// File: rtl/tbl_row_latch.sv
module tbl_row_latch #(
  parameter int PW    = 24,
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic          wr_byte,
  input  logic          wr_odd,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [IW-1:0] rd_idx,
  output logic [PW-1:0] rd_word
);
  localparam int BW = DW / 2;

  logic [PW-1:0] lat [DEPTH];
  logic [PW-1:0] cur, nxt;

  // merge the incoming half or byte into the current entry
  always_comb begin
    cur = lat[wr_idx];
    nxt = cur;
    if (!wr_hi) begin
      if (!wr_byte)    nxt[DW-1:0]   = wr_data;
      else if (wr_odd) nxt[DW-1:BW]  = wr_data[BW-1:0];
      else             nxt[BW-1:0]   = wr_data[BW-1:0];
    end else if (!(wr_byte && wr_odd)) begin
      nxt[PW-1:DW] = wr_data[PW-DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) lat[i] <= '1;
    end else begin
      if (clr_en) lat[rd_idx] <= '1;
      if (wr_en)  lat[wr_idx] <= nxt;
    end
  end

  assign rd_word = lat[rd_idx];

  AST_LATCH_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && clr_en)); // R9

endmodule

// File: rtl/tbl_rd_format.sv
module tbl_rd_format #(
  parameter int PW = 24,
  parameter int DW = 16
) (
  input  logic [PW-1:0] word,
  input  logic          is_hi,
  input  logic          is_byte,
  input  logic          odd,
  output logic [DW-1:0] data
);
  localparam int BW = DW / 2;

  always_comb begin
    if (!is_hi) begin
      if (!is_byte)  data = word[DW-1:0];
      else if (odd)  data = DW'(word[DW-1:BW]);
      else           data = DW'(word[BW-1:0]);
    end else begin
      if (is_byte && odd) data = '0;
      else                data = DW'(word[PW-1:DW]);
    end
  end

endmodule

// File: rtl/tbl_seq.sv
module tbl_seq import tbl_pkg::*; #(
  parameter int AW          = 23,
  parameter int PW          = 24,
  parameter int ROW_WORDS   = 64,
  parameter int ERASE_WORDS = 512,
  parameter int IW          = $clog2(ROW_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  tbl_op_e       start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [PW-1:0] mem_rdata,
  input  logic [PW-1:0] lat_word,
  output logic          busy,
  output logic          cap,
  output logic          mem_rd_en,
  output logic          mem_we,
  output logic          mem_cfg,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] mem_wdata,
  output logic [IW-1:0] lat_idx,
  output logic          lat_clr
);
  localparam int CW = $clog2(ERASE_WORDS) + 1;
  localparam logic [AW-1:0] ROW_MASK  = ~AW'(ROW_WORDS - 1);
  localparam logic [AW-1:0] PAGE_MASK = ~AW'(ERASE_WORDS - 1);

  seq_state_e    state;
  logic [AW-1:0] base;
  logic [CW-1:0] cnt, last;
  logic [AW-1:0] cur_addr;

  assign cur_addr  = base + AW'(cnt);
  assign mem_addr  = cur_addr;
  assign mem_cfg   = cur_addr[AW-1];
  assign lat_idx   = cur_addr[IW-1:0];
  assign busy      = (state != S_IDLE);
  assign cap       = (state == S_RD_CAP);
  assign mem_rd_en = (state == S_RD_ISSUE) || (state == S_PG_RD);
  assign mem_we    = (state == S_PG_WR) || (state == S_ERASE);
  assign lat_clr   = (state == S_PG_WR);
  assign mem_wdata = (state == S_ERASE) ? '1 : (mem_rdata & lat_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      base  <= '0;
      cnt   <= '0;
      last  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          cnt <= '0;
          unique case (start_op)
            OP_RD_LO, OP_RD_HI: begin
              base  <= start_addr;
              state <= S_RD_ISSUE;
            end
            OP_PROG_WORD: begin
              base  <= start_addr;
              last  <= '0;
              state <= S_PG_RD;
            end
            OP_PROG_ROW: begin
              base  <= start_addr & ROW_MASK;
              last  <= CW'(ROW_WORDS - 1);
              state <= S_PG_RD;
            end
            OP_ERASE_PAGE: begin
              base  <= start_addr & PAGE_MASK;
              last  <= CW'(ERASE_WORDS - 1);
              state <= S_ERASE;
            end
            default: state <= S_IDLE;
          endcase
        end
        S_RD_ISSUE: state <= S_RD_CAP;
        S_RD_CAP:   state <= S_IDLE;
        S_PG_RD:    state <= S_PG_WR;
        S_PG_WR: begin
          if (cnt == last) state <= S_IDLE;
          else begin
            cnt   <= cnt + 1'b1;
            state <= S_PG_RD;
          end
        end
        S_ERASE: begin
          if (cnt == last) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> (state == S_IDLE)); // R9
  AST_PROG_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == S_PG_WR) |-> (mem_addr == $past(mem_addr))); // R6
  AST_CAP_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD_CAP) |-> $past(mem_rd_en)); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= last)); // R8

endmodule

// File: rtl/tbl_bridge.sv
module tbl_bridge import tbl_pkg::*; #(
  parameter int PAGE_W      = 8,
  parameter int EA_W        = 16,
  parameter int DW          = 16,
  parameter int PW          = 24,
  parameter int ROW_WORDS   = 64,
  parameter int ERASE_WORDS = 512
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [2:0]               req_op,
  input  logic                     req_byte,
  input  logic [PAGE_W-1:0]        page_sel,
  input  logic [EA_W-1:0]          eff_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_valid,
  output logic                     busy,
  output logic                     err,
  output logic                     mem_rd_en,
  output logic                     mem_we,
  output logic                     mem_cfg,
  output logic [PAGE_W+EA_W-2:0]   mem_addr,
  output logic [PW-1:0]            mem_wdata,
  input  logic [PW-1:0]            mem_rdata
);
  localparam int AW = PAGE_W + EA_W - 1;
  localparam int IW = $clog2(ROW_WORDS);

  tbl_op_e       op;
  logic          accept, start, lat_wr;
  logic [AW-1:0] word_idx;
  logic          fmt_hi, fmt_byte, fmt_odd;
  logic [DW-1:0] fmt_out;
  logic [PW-1:0] lat_word;
  logic [IW-1:0] lat_idx;
  logic          lat_clr, cap;

  assign op       = tbl_op_e'(req_op);
  assign word_idx = {page_sel, eff_addr[EA_W-1:1]};
  assign accept   = req_valid && !busy;
  assign lat_wr   = accept && (op == OP_WR_LO || op == OP_WR_HI);
  assign start    = accept && (op == OP_RD_LO || op == OP_RD_HI ||
                               op == OP_PROG_WORD || op == OP_PROG_ROW ||
                               op == OP_ERASE_PAGE);

  tbl_row_latch #(.PW(PW), .DW(DW), .DEPTH(ROW_WORDS), .IW(IW)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (lat_wr),
    .wr_hi   (op == OP_WR_HI),
    .wr_byte (req_byte),
    .wr_odd  (eff_addr[0]),
    .wr_idx  (eff_addr[IW:1]),
    .wr_data (wr_data),
    .clr_en  (lat_clr),
    .rd_idx  (lat_idx),
    .rd_word (lat_word)
  );

  tbl_seq #(.AW(AW), .PW(PW), .ROW_WORDS(ROW_WORDS),
            .ERASE_WORDS(ERASE_WORDS), .IW(IW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_op   (op),
    .start_addr (word_idx),
    .mem_rdata  (mem_rdata),
    .lat_word   (lat_word),
    .busy       (busy),
    .cap        (cap),
    .mem_rd_en  (mem_rd_en),
    .mem_we     (mem_we),
    .mem_cfg    (mem_cfg),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .lat_idx    (lat_idx),
    .lat_clr    (lat_clr)
  );

  tbl_rd_format #(.PW(PW), .DW(DW)) u_fmt (
    .word    (mem_rdata),
    .is_hi   (fmt_hi),
    .is_byte (fmt_byte),
    .odd     (fmt_odd),
    .data    (fmt_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_hi   <= 1'b0;
      fmt_byte <= 1'b0;
      fmt_odd  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      err      <= req_valid && busy;
      rd_valid <= cap;
      if (cap) rd_data <= fmt_out;
      if (start) begin
        fmt_hi   <= (op == OP_RD_HI);
        fmt_byte <= req_byte;
        fmt_odd  <= eff_addr[0];
      end
    end
  end

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && busy) |=> err); // R9
  AST_ERR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(busy)); // R9
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R2
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we); // R5

endmodule

// File: tb/tbl_bridge_bench.sv
`timescale 1ns/1ps
module tbl_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd7;
  logic        req_byte = 1'b0;
  logic [7:0]  page_sel = '0;
  logic [15:0] eff_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid, busy, err, mem_rd_en, mem_we, mem_cfg;
  logic [22:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata;

  int total = 0;
  int bad   = 0;
  logic init_go = 1'b0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  tbl_bridge u_tbl_bridge (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_byte(req_byte), .page_sel(page_sel), .eff_addr(eff_addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .err(err), .mem_rd_en(mem_rd_en), .mem_we(mem_we), .mem_cfg(mem_cfg),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // behavioural array: configuration half selected by mem_cfg
  logic [23:0] mem [4096];
  logic [23:0] ref_m [4096];
  logic [23:0] lat_ref [64];

  function automatic logic [23:0] pat(int i);
    return 24'(i * 40503) ^ 24'hC3A55A;
  endfunction

  function automatic int ridx(logic [7:0] pg, logic [15:0] ea);
    return int'({pg[7], ea[11:1]});
  endfunction

  always @(posedge clk) begin
    if (init_go) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
    end else begin
      if (mem_we) mem[{mem_cfg, mem_addr[10:0]}] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= mem[{mem_cfg, mem_addr[10:0]}];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(logic [2:0] op, logic byt, logic odd, logic [23:0] w);
    if (op == 3'd0) begin
      if (!byt) return w[15:0];
      return odd ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
    end
    if (byt && odd) return 16'h0;
    return {8'h0, w[23:16]};
  endfunction

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input logic [2:0] op, input logic byt, input logic [7:0] pg,
                    input logic [15:0] ea, output logic [15:0] d);
    wait_idle();
    req_valid = 1'b1; req_op = op; req_byte = byt; page_sel = pg; eff_addr = ea;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !rd_valid, "R2 busy during read", int'(busy), 1);
    chk(mem_addr == {pg, ea[15:1]} && mem_rd_en, "R1 word index", int'(mem_addr), int'({pg, ea[15:1]}));
    chk(mem_cfg == pg[7], "R1 space select", int'(mem_cfg), int'(pg[7]));
    @(negedge clk);
    @(negedge clk);
    chk(rd_valid && !busy, "R2 read strobe", int'(rd_valid), 1);
    d = rd_data;
    @(negedge clk);
    chk(!rd_valid, "R2 strobe one cycle", int'(rd_valid), 0);
  endtask

  task automatic wr(input logic [2:0] op, input logic byt, input logic [15:0] ea,
                    input logic [15:0] d);
    logic [5:0] k = ea[6:1];
    wait_idle();
    req_valid = 1'b1; req_op = op; req_byte = byt; page_sel = 8'h00; eff_addr = ea; wr_data = d;
    if (op == 3'd2) begin
      if (!byt) lat_ref[k][15:0] = d;
      else if (ea[0]) lat_ref[k][15:8] = d[7:0];
      else lat_ref[k][7:0] = d[7:0];
    end else if (!(byt && ea[0])) begin
      lat_ref[k][23:16] = d[7:0];
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!busy, "R5 write leaves busy low", int'(busy), 0);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] pg, input logic [15:0] ea,
                     output int cycles);
    wait_idle();
    req_valid = 1'b1; req_op = op; req_byte = 1'b0; page_sel = pg; eff_addr = ea;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 0;
    while (busy && cycles < 2000) begin cycles++; @(negedge clk); end
  endtask

  task automatic check_word(input logic [7:0] pg, input logic [15:0] ea, input string tag);
    logic [15:0] lo, hi;
    logic [23:0] w = ref_m[ridx(pg, ea)];
    rd(3'd0, 1'b0, pg, ea, lo);
    rd(3'd1, 1'b0, pg, ea, hi);
    chk({hi[7:0], lo} == w && hi[15:8] == 8'h0, tag, int'({hi[7:0], lo}), int'(w));
  endtask

  task automatic test_reset();
    chk(!busy, "R10 busy after reset", int'(busy), 0);
    chk(!rd_valid, "R10 rd_valid after reset", int'(rd_valid), 0);
    chk(!err, "R10 err after reset", int'(err), 0);
  endtask

  task automatic test_reads();
    logic [7:0]  pgs [4] = '{8'h00, 8'h00, 8'h80, 8'h80};
    logic [15:0] eas [4] = '{16'h0010, 16'h0011, 16'h0246, 16'h0FFF};
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      for (int m = 0; m < 4; m++) begin
        logic [2:0] op = (m < 2) ? 3'd0 : 3'd1;
        logic byt = m[0];
        logic [23:0] w = ref_m[ridx(pgs[a], eas[a])];
        rd(op, byt, pgs[a], eas[a], d);
        chk(d == exp_rd(op, byt, eas[a][0], w), op == 3'd0 ? "R3 low read" : "R4 high read",
            int'(d), int'(exp_rd(op, byt, eas[a][0], w)));
      end
    end
  endtask

  task automatic test_word_prog();
    int c;
    int i;
    wr(3'd2, 1'b0, 16'h0100, 16'hF0F0);
    wr(3'd3, 1'b1, 16'h0100, 16'h003C);
    wr(3'd3, 1'b1, 16'h0101, 16'h0000);
    check_word(8'h00, 16'h0100, "R5 array untouched by writes");
    cmd(3'd4, 8'h00, 16'h0100, c);
    chk(c == 2, "R7 word program busy length", c, 2);
    i = ridx(8'h00, 16'h0100);
    ref_m[i] = ref_m[i] & lat_ref[0];
    lat_ref[0] = '1;
    check_word(8'h00, 16'h0100, "R7 programmed word");
    check_word(8'h00, 16'h0102, "R7 neighbour unchanged");
    wr(3'd2, 1'b1, 16'h0105, 16'h00A5);
    wr(3'd2, 1'b1, 16'h0104, 16'h005A);
    cmd(3'd4, 8'h00, 16'h0104, c);
    i = ridx(8'h00, 16'h0104);
    ref_m[i] = ref_m[i] & lat_ref[2];
    lat_ref[2] = '1;
    check_word(8'h00, 16'h0104, "R5 byte merge programmed");
  endtask

  task automatic test_row_prog();
    int c;
    for (int k = 0; k < 64; k += 7) begin
      wr(3'd2, 1'b0, 16'h0200 + 16'(2 * k), 16'(k * 16'h0913) ^ 16'h7E3C);
      wr(3'd3, 1'b0, 16'h0200 + 16'(2 * k), 16'(k * 3));
    end
    cmd(3'd5, 8'h00, 16'h0237, c);
    chk(c == 128, "R6 row program busy length", c, 128);
    for (int k = 0; k < 64; k++) begin
      ref_m[256 + k] = ref_m[256 + k] & lat_ref[k];
      lat_ref[k] = '1;
    end
    for (int k = 0; k < 64; k += 7) check_word(8'h00, 16'h0200 + 16'(2 * k), "R6 row word");
    check_word(8'h00, 16'h027E, "R6 last row word");
    check_word(8'h00, 16'h01FE, "R6 word below row");
    check_word(8'h00, 16'h0280, "R6 word above row");
    cmd(3'd5, 8'h00, 16'h0200, c);
    check_word(8'h00, 16'h0200, "R10 latch restored to ones");
    check_word(8'h00, 16'h020E, "R10 latch restored to ones");
  endtask

  task automatic test_erase();
    int c;
    cmd(3'd6, 8'h80, 16'h0500, c);
    chk(c == 512, "R8 erase busy length", c, 512);
    for (int w = 512; w < 1024; w++) ref_m[2048 + w] = 24'hFFFFFF;
    check_word(8'h80, 16'h03FE, "R8 word below page");
    check_word(8'h80, 16'h0400, "R8 first erased word");
    check_word(8'h80, 16'h0556, "R8 middle erased word");
    check_word(8'h80, 16'h07FE, "R8 last erased word");
    check_word(8'h80, 16'h0800, "R8 word above page");
    check_word(8'h00, 16'h0500, "R8 other space unchanged");
  endtask

  task automatic test_busy_reject();
    int c;
    wait_idle();
    req_valid = 1'b1; req_op = 3'd6; page_sel = 8'h00; eff_addr = 16'h0C00;
    @(negedge clk);
    req_op = 3'd2; req_byte = 1'b0; eff_addr = 16'h0C0A; wr_data = 16'h0000;
    @(negedge clk);
    chk(err, "R9 error flag raised", int'(err), 1);
    req_op = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!err, "R9 error flag one cycle", int'(err), 0);
    for (int n = 0; n < 3; n++) begin
      chk(!rd_valid, "R9 rejected read gives no result", int'(rd_valid), 0);
      @(negedge clk);
    end
    for (int w = 1536; w < 2048; w++) ref_m[w] = 24'hFFFFFF;
    wait_idle();
    wr(3'd2, 1'b0, 16'h0C02, 16'hFFFF);
    cmd(3'd4, 8'h00, 16'h0C0A, c);
    check_word(8'h00, 16'h0C0A, "R9 rejected write left latch clear");
  endtask

  task automatic test_nop();
    wait_idle();
    req_valid = 1'b1; req_op = 3'd7; page_sel = 8'h00; eff_addr = 16'h0100;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 3; n++) begin
      chk(!busy && !err && !rd_valid && !mem_we, "R11 no-op has no effect",
          int'({busy, err, rd_valid, mem_we}), 0);
      @(negedge clk);
    end
    check_word(8'h00, 16'h0100, "R11 array unchanged");
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) ref_m[i] = pat(i);
    for (int k = 0; k < 64; k++) lat_ref[k] = '1;
    init_go = 1'b1;
    repeat (3) @(posedge clk);
    init_go = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_reads();
    test_word_prog();
    test_row_prog();
    test_erase();
    test_busy_reject();
    test_nop();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule